// File: doc/BRIEF.md
# Paged Monochrome LCD Framebuffer Controller

This block holds the picture for a 128 by 64 one-bit-per-pixel display. Its video memory has eight horizontal bands of eight rows each, called pages. Each page holds 128 column bytes, and bit n of a byte is row n of that band. Software drives the block through a 32-bit register bus. It picks a transfer mode, issues page-select commands and streams pixel bytes. A column pointer advances after every stored byte and wraps within the current page.

Writes to the data register mean different things depending on a mode latch. In pixel mode each write is stored as a byte. In command mode each write is decoded as a page-select command. In the invalid mode every data write is thrown away. The mode latch accepts only two exact 32-bit words. Any other word written to it puts the block in the invalid mode.

A 3-bit brightness level is loaded through a strobe and scales the colour of lit pixels. A scan-out port takes a pixel coordinate and returns that pixel's 24-bit colour one clock later.

Top module: `mono_page_fb`

## Requirements
- R1: While `rst` is high at a clock edge, the block returns to its reset state: mode invalid, page 0, column 0, brightness level 7, every video byte zero, and `bus_rdata` and `scan_rgb` zero.
- R2: A write to offset 0x1AC sets the mode to pixel mode if the word is exactly 0x00100011, and to command mode if it is exactly 0x00104011. Any other word sets the mode to invalid.
- R3: A write of 0xB0 to 0xB7 to offset 0x1BC selects page (value − 0xB0) and sets the column to 0. Any other value written there changes neither the page nor the column.
- R4: In command mode, a write of 0xB0 to 0xB7 to offset 0x1C0 selects the page and clears the column, in the same way as R3. Other values are ignored and no byte is stored.
- R5: In the invalid mode, writes to offset 0x1C0 store nothing and leave the page and column unchanged.
- R6: In pixel mode, a write to offset 0x1C0 stores bits 7:0 of the word at video byte page*128 + column, then adds one to the column.
- R7: When the column is 127, a pixel-mode data write stores the byte and sets the column to 0 on the same page.
- R8: `scan_rgb` shows pixel (`scan_x`, `scan_y`) one clock after the coordinate is sampled. A pixel is lit when bit (y mod 8) of video byte x + (y/8)*128 is 1. An unlit pixel reads 0.
- R9: A lit pixel reads as base colour 0xE0E0FF scaled by the brightness level L, which is loaded from `lvl_in` when `lvl_we` is high. L = 7 gives the full colour and L = 0 gives 0. For any other L, each 8-bit channel c becomes floor(c*L/7). The level used is the one held before the sampling edge.
- R10: A read of offset 0x180 returns the last word written there, on `bus_rdata` one clock after `bus_rd`. A read of any other offset, or a cycle without `bus_rd`, gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 12 | Register byte offset |
| bus_wdata | input | 32 | Write word |
| bus_rdata | output | 32 | Read word, one clock after bus_rd |
| lvl_we | input | 1 | Brightness load strobe |
| lvl_in | input | 3 | Brightness level to load |
| scan_x | input | 7 | Scan-out column |
| scan_y | input | 6 | Scan-out row |
| scan_rgb | output | 24 | Scaled colour of the scanned pixel |

## Verification
The assertions assume that every bus input carries a known value on each sampled edge. They also assume that a read and a write do not target the interrupt-control word in the same cycle, and that the level strobe is decoded independently of bus traffic. The stimulus drives all inputs from one process on the falling edge. It never raises the read and write strobes together, and it holds every input at a defined value from time zero. This keeps the one-clock read and scan-out latencies unambiguous for the reference model.

// File: rtl/lcdfb_pkg.sv
`timescale 1ns/1ps
package lcdfb_pkg;

    localparam int unsigned BUS_W = 32;
    localparam int unsigned OFS_W = 12;
    localparam int unsigned RGB_W = 24;

    localparam logic [OFS_W-1:0] OFS_IRQ   = 12'h180;
    localparam logic [OFS_W-1:0] OFS_MODE  = 12'h1AC;
    localparam logic [OFS_W-1:0] OFS_INSTR = 12'h1BC;
    localparam logic [OFS_W-1:0] OFS_DATA  = 12'h1C0;

    localparam logic [BUS_W-1:0] MAGIC_PIX = 32'h0010_0011;
    localparam logic [BUS_W-1:0] MAGIC_CMD = 32'h0010_4011;
    localparam logic [BUS_W-1:0] PAGE_CMD_LO = 32'h0000_00B0;

    typedef enum logic [1:0] {
        XFER_OFF = 2'd0,
        XFER_PIX = 2'd1,
        XFER_CMD = 2'd2
    } xfer_mode_e;

    // One colour channel multiplied by level/7, rounded toward zero.
    function automatic logic [7:0] scale_chan(input logic [7:0] c, input logic [2:0] lvl);
        logic [10:0] prod;
        prod = {3'b000, c} * {8'h00, lvl};
        if (lvl == 3'd7) begin
            return c;
        end
        return 8'(prod / 11'd7);
    endfunction

endpackage

// File: rtl/lcdfb_regif.sv
`timescale 1ns/1ps
module lcdfb_regif
    import lcdfb_pkg::*;
#(
    parameter int unsigned COLS  = 128,
    parameter int unsigned PAGES = 8,
    localparam int unsigned COL_W  = $clog2(COLS),
    localparam int unsigned PAGE_W = $clog2(PAGES),
    localparam int unsigned VA_W   = COL_W + PAGE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [OFS_W-1:0]  addr,
    input  logic [BUS_W-1:0]  wdata,
    input  logic              lvl_we,
    input  logic [2:0]        lvl_in,
    output logic [BUS_W-1:0]  rdata,
    output logic              ram_we,
    output logic [VA_W-1:0]   ram_waddr,
    output logic [7:0]        ram_wbyte,
    output xfer_mode_e        mode_o,
    output logic [PAGE_W-1:0] page_o,
    output logic [COL_W-1:0]  col_o,
    output logic [2:0]        lvl_o
);

    typedef struct packed {
        xfer_mode_e         mode;
        logic [PAGE_W-1:0]  page;
        logic [COL_W-1:0]   col;
        logic [2:0]         lvl;
        logic [BUS_W-1:0]   irq;
        logic [BUS_W-1:0]   rdata;
    } ctl_t;

    ctl_t st_d, st_q;

    logic [BUS_W-1:0] rel_d;
    logic             sel_d;

    always_comb begin
        // Distance from the first page-select code and whether it is in range.
        rel_d = wdata - PAGE_CMD_LO;
        sel_d = (wdata >= PAGE_CMD_LO) && (rel_d < BUS_W'(PAGES));

        st_d      = st_q;
        ram_we    = 1'b0;
        ram_waddr = {st_q.page, st_q.col};
        ram_wbyte = wdata[7:0];

        st_d.rdata = '0;
        if (rd_en && addr == OFS_IRQ) begin
            st_d.rdata = st_q.irq;
        end

        if (lvl_we) begin
            st_d.lvl = lvl_in;
        end

        if (wr_en) begin
            unique case (addr)
                OFS_IRQ: st_d.irq = wdata;
                OFS_MODE: begin
                    if (wdata == MAGIC_PIX) begin
                        st_d.mode = XFER_PIX;
                    end else if (wdata == MAGIC_CMD) begin
                        st_d.mode = XFER_CMD;
                    end else begin
                        st_d.mode = XFER_OFF;
                    end
                end
                OFS_INSTR: begin
                    if (sel_d) begin
                        st_d.page = rel_d[PAGE_W-1:0];
                        st_d.col  = '0;
                    end
                end
                OFS_DATA: begin
                    unique case (st_q.mode)
                        XFER_PIX: begin
                            ram_we   = 1'b1;
                            st_d.col = st_q.col + 1'b1;
                        end
                        XFER_CMD: begin
                            if (sel_d) begin
                                st_d.page = rel_d[PAGE_W-1:0];
                                st_d.col  = '0;
                            end
                        end
                        default: ;
                    endcase
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.mode  <= XFER_OFF;
            st_q.page  <= '0;
            st_q.col   <= '0;
            st_q.lvl   <= 3'd7;
            st_q.irq   <= '0;
            st_q.rdata <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata  = st_q.rdata;
    assign mode_o = st_q.mode;
    assign page_o = st_q.page;
    assign col_o  = st_q.col;
    assign lvl_o  = st_q.lvl;

endmodule

// File: rtl/lcdfb_vram.sv
`timescale 1ns/1ps
module lcdfb_vram #(
    parameter int unsigned DEPTH = 1024,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wbyte,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rbyte
);

    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= 8'h00;
            end
        end else if (we) begin
            mem_q[waddr] <= wbyte;
        end
    end

    assign rbyte = mem_q[raddr];

endmodule

// File: rtl/lcdfb_scan.sv
`timescale 1ns/1ps
module lcdfb_scan
    import lcdfb_pkg::*;
#(
    parameter logic [RGB_W-1:0] BASE_RGB = 24'hE0E0FF,
    localparam int unsigned NCH = RGB_W / 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lit,
    input  logic [2:0]       lvl,
    output logic [RGB_W-1:0] rgb
);

    logic [RGB_W-1:0] shade_d;
    logic [RGB_W-1:0] rgb_d, rgb_q;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        assign shade_d[ch*8 +: 8] = scale_chan(BASE_RGB[ch*8 +: 8], lvl);
    end

    always_comb begin
        rgb_d = lit ? shade_d : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rgb_q <= '0;
        end else begin
            rgb_q <= rgb_d;
        end
    end

    assign rgb = rgb_q;

endmodule

// File: rtl/mono_page_fb.sv
`timescale 1ns/1ps
module mono_page_fb
    import lcdfb_pkg::*;
#(
    parameter int unsigned      COLS     = 128,
    parameter int unsigned      ROWS     = 64,
    parameter logic [23:0]      BASE_RGB = 24'hE0E0FF,
    localparam int unsigned PAGES  = ROWS / 8,
    localparam int unsigned COL_W  = $clog2(COLS),
    localparam int unsigned ROW_W  = $clog2(ROWS),
    localparam int unsigned PAGE_W = $clog2(PAGES),
    localparam int unsigned VA_W   = COL_W + PAGE_W,
    localparam int unsigned DEPTH  = 1 << VA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [11:0]       bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              lvl_we,
    input  logic [2:0]        lvl_in,
    input  logic [COL_W-1:0]  scan_x,
    input  logic [ROW_W-1:0]  scan_y,
    output logic [23:0]       scan_rgb
);

    xfer_mode_e        xfer_mode;
    logic [PAGE_W-1:0] cur_page;
    logic [COL_W-1:0]  cur_col;
    logic [2:0]        cur_lvl;
    logic              ram_we;
    logic [VA_W-1:0]   ram_waddr;
    logic [7:0]        ram_wbyte;
    logic [VA_W-1:0]   scan_addr;
    logic [7:0]        scan_byte;
    logic              scan_lit;

    lcdfb_regif #(
        .COLS  (COLS),
        .PAGES (PAGES)
    ) u_regif (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (bus_wr),
        .rd_en     (bus_rd),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .lvl_we    (lvl_we),
        .lvl_in    (lvl_in),
        .rdata     (bus_rdata),
        .ram_we    (ram_we),
        .ram_waddr (ram_waddr),
        .ram_wbyte (ram_wbyte),
        .mode_o    (xfer_mode),
        .page_o    (cur_page),
        .col_o     (cur_col),
        .lvl_o     (cur_lvl)
    );

    // Page index is the row's band; column is the byte within it.
    assign scan_addr = {scan_y[ROW_W-1:3], scan_x};
    assign scan_lit  = scan_byte[scan_y[2:0]];

    lcdfb_vram #(
        .DEPTH (DEPTH)
    ) u_vram (
        .clk   (clk),
        .rst   (rst),
        .we    (ram_we),
        .waddr (ram_waddr),
        .wbyte (ram_wbyte),
        .raddr (scan_addr),
        .rbyte (scan_byte)
    );

    lcdfb_scan #(
        .BASE_RGB (BASE_RGB)
    ) u_scan (
        .clk (clk),
        .rst (rst),
        .lit (scan_lit),
        .lvl (cur_lvl),
        .rgb (scan_rgb)
    );

endmodule

// File: rtl/lcdfb_checker.sv
`timescale 1ns/1ps
module lcdfb_checker
    import lcdfb_pkg::*;
#(
    parameter int unsigned COL_W  = 7,
    parameter int unsigned PAGE_W = 3,
    parameter int unsigned COLS   = 128,
    parameter int unsigned PAGES  = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              wr,
    input logic              rd,
    input logic [11:0]       addr,
    input logic [31:0]       wdata,
    input logic [31:0]       rdata,
    input xfer_mode_e        mode,
    input logic [PAGE_W-1:0] page,
    input logic [COL_W-1:0]  col,
    input logic [2:0]        lvl,
    input logic [23:0]       rgb
);

    logic sel_code;
    assign sel_code = (wdata >= PAGE_CMD_LO) && (wdata < PAGE_CMD_LO + 32'(PAGES));

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (mode == XFER_OFF && page == '0 && col == '0 && lvl == 3'd7 && rdata == '0));

    assert_bad_mode_R2: assert property (@(posedge clk) disable iff (rst)
        (wr && addr == OFS_MODE && wdata != MAGIC_PIX && wdata != MAGIC_CMD) |=> mode == XFER_OFF);

    assert_cmd_mode_R2: assert property (@(posedge clk) disable iff (rst)
        (wr && addr == OFS_MODE && wdata == MAGIC_CMD) |=> mode == XFER_CMD);

    assert_page_select_R3: assert property (@(posedge clk) disable iff (rst)
        (wr && addr == OFS_INSTR && sel_code) |=>
            (page == PAGE_W'($past(wdata) - PAGE_CMD_LO) && col == '0));

    assert_cmd_ignore_R4: assert property (@(posedge clk) disable iff (rst)
        (wr && addr == OFS_DATA && mode == XFER_CMD && !sel_code) |=> ($stable(page) && $stable(col)));

    assert_off_drop_R5: assert property (@(posedge clk) disable iff (rst)
        (wr && addr == OFS_DATA && mode == XFER_OFF) |=> ($stable(page) && $stable(col) && mode == XFER_OFF));

    assert_col_step_R6: assert property (@(posedge clk) disable iff (rst)
        (wr && addr == OFS_DATA && mode == XFER_PIX) |=> col == COL_W'($past(col) + 1'b1));

    assert_col_wrap_R7: assert property (@(posedge clk) disable iff (rst)
        (wr && addr == OFS_DATA && mode == XFER_PIX && col == COL_W'(COLS - 1)) |=>
            (col == '0 && $stable(page)));

    assert_dark_level_R9: assert property (@(posedge clk) disable iff (rst)
        (lvl == 3'd0) |=> rgb == '0);

    assert_read_other_R10: assert property (@(posedge clk) disable iff (rst)
        (!rd || addr != OFS_IRQ) |=> rdata == '0);

endmodule

bind mono_page_fb lcdfb_checker #(
    .COL_W  (COL_W),
    .PAGE_W (PAGE_W),
    .COLS   (COLS),
    .PAGES  (PAGES)
) u_chk (
    .clk   (clk),
    .rst   (rst),
    .wr    (bus_wr),
    .rd    (bus_rd),
    .addr  (bus_addr),
    .wdata (bus_wdata),
    .rdata (bus_rdata),
    .mode  (xfer_mode),
    .page  (cur_page),
    .col   (cur_col),
    .lvl   (cur_lvl),
    .rgb   (scan_rgb)
);

// File: tb/sim_mono_page_fb.sv
`timescale 1ns/1ps
module sim_mono_page_fb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        lvl_we = 1'b0;
    logic [2:0]  lvl_in = '0;
    logic [6:0]  scan_x = '0;
    logic [5:0]  scan_y = '0;
    logic [23:0] scan_rgb;

    int checks = 0;
    int errors = 0;

    // Reference model state
    byte unsigned vram_m [1024];
    int           page_m, col_m, mode_m, lvl_m;
    logic [31:0]  irq_m;

    always #5 clk = ~clk;

    mono_page_fb u0 (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .lvl_we    (lvl_we),
        .lvl_in    (lvl_in),
        .scan_x    (scan_x),
        .scan_y    (scan_y),
        .scan_rgb  (scan_rgb)
    );

    function automatic int shade(input int c, input int l);
        if (l == 7) return c;
        return (c * l) / 7;
    endfunction

    function automatic logic [23:0] pix_exp(input int x, input int y, input int l);
        int b;
        b = vram_m[x + (y / 8) * 128];
        if (((b >> (y % 8)) & 1) == 0) return 24'h0;
        return {8'(shade(8'hE0, l)), 8'(shade(8'hE0, l)), 8'(shade(8'hFF, l))};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // One clock: predict, advance the model, compare after the edge.
    task automatic step(input string tag);
        logic [23:0] e_rgb;
        logic [31:0] e_rd;
        bit          sel;
        int          rel;
        e_rgb = pix_exp(scan_x, scan_y, lvl_m);
        e_rd  = (bus_rd && bus_addr == 12'h180) ? irq_m : 32'h0;
        if (rst) begin
            e_rgb = 0; e_rd = 0;
            foreach (vram_m[i]) vram_m[i] = 0;
            page_m = 0; col_m = 0; mode_m = 0; lvl_m = 7; irq_m = 0;
        end else begin
            if (lvl_we) lvl_m = lvl_in;
            rel = int'(bus_wdata) - 'hB0;
            sel = (bus_wdata >= 32'hB0) && (bus_wdata <= 32'hB7);
            if (bus_wr) begin
                case (bus_addr)
                    12'h180: irq_m = bus_wdata;
                    12'h1AC: mode_m = (bus_wdata == 32'h00100011) ? 1 :
                                      (bus_wdata == 32'h00104011) ? 2 : 0;
                    12'h1BC: if (sel) begin page_m = rel; col_m = 0; end
                    12'h1C0: begin
                        if (mode_m == 1) begin
                            vram_m[page_m * 128 + col_m] = bus_wdata[7:0];
                            col_m = (col_m + 1) % 128;
                        end else if (mode_m == 2 && sel) begin
                            page_m = rel; col_m = 0;
                        end
                    end
                    default: ;
                endcase
            end
        end
        @(posedge clk);
        #1;
        check(rst ? "R1 rgb" : tag, {8'h0, scan_rgb}, {8'h0, e_rgb});
        check(rst ? "R1 rdata" : "R10 rdata", bus_rdata, e_rd);
        @(negedge clk);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input string tag);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        step(tag);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a);
        bus_rd = 1'b1; bus_addr = a;
        step("R10");
        bus_rd = 1'b0;
    endtask

    task automatic set_lvl(input int l);
        lvl_we = 1'b1; lvl_in = 3'(l);
        step("R9");
        lvl_we = 1'b0;
    endtask

    task automatic sweep(input string tag);
        for (int y = 0; y < 64; y++) begin
            for (int x = 0; x < 128; x++) begin
                scan_x = 7'(x); scan_y = 6'(y);
                step(tag);
            end
        end
    endtask

    initial begin
        #1_900_000;
        errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        rst = 1'b1;
        for (int i = 0; i < 3; i++) step("R1");
        rst = 1'b0;
        step("R1");
        sweep("R1 blank screen");

        // R10: interrupt-control word and other offsets
        rd(12'h180);
        wr(12'h180, 32'hDEAD_BEEF, "R10");
        rd(12'h180);
        rd(12'h1AC);
        rd(12'h1C0);
        rd(12'h004);

        // R5: invalid mode drops data
        wr(12'h1C0, 32'h0000_00FF, "R5");
        wr(12'h1C0, 32'h0000_00B2, "R5");

        // R6, R7: pixel mode fill of page 0 with a wrap
        wr(12'h1AC, 32'h0010_0011, "R2");
        for (int i = 0; i < 130; i++) wr(12'h1C0, 32'hABCD_0000 | (i ^ 'h5A), "R6");

        // R3: page select and ignored code
        wr(12'h1BC, 32'h0000_00B3, "R3");
        for (int i = 0; i < 4; i++) wr(12'h1C0, 32'h0000_0011 << i, "R6");
        wr(12'h1BC, 32'h0000_00B8, "R3");
        wr(12'h1BC, 32'h0001_00B1, "R3");
        wr(12'h1C0, 32'h0000_00C3, "R3");

        // R2: near-miss word makes the mode invalid
        wr(12'h1AC, 32'h0010_0012, "R2");
        wr(12'h1C0, 32'h0000_00EE, "R5");

        // R4: command mode
        wr(12'h1AC, 32'h0010_4011, "R2");
        wr(12'h1C0, 32'h0000_00B7, "R4");
        wr(12'h1C0, 32'h0000_0042, "R4");
        wr(12'h1AC, 32'h0010_0011, "R2");
        wr(12'h1C0, 32'h0000_0081, "R4");
        wr(12'h1C0, 32'h0000_0024, "R4");
        sweep("R8 full level");

        // R9: brightness scaling
        set_lvl(0);
        sweep("R9 level 0");
        set_lvl(3);
        sweep("R9 level 3");
        set_lvl(5);
        sweep("R9 level 5");

        // R1: reset clears everything again
        rst = 1'b1;
        step("R1");
        rst = 1'b0;
        rd(12'h180);
        sweep("R1 cleared");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule